// File: doc/BRIEF.md
# PPU Pattern and Nametable Bank Translator

This block turns a picture-processor address into the physical 1KB page behind it. The address space it covers has two parts. Pattern space (0x0000 to 0x1FFF) is split into eight 1KB slots. Each slot resolves to a page number in character ROM. Nametable space (0x2000 to 0x2FFF) is split into four 1KB quadrants. A quadrant resolves either to a character-ROM page or to a one-bit page select into the console's own nametable RAM.

Two things drive the translation. The first is an 8-bit banking-mode value. The second is eight character bank registers, supplied as one flat vector with register i in bits [i*BANK_W +: BANK_W]. Both are written elsewhere. Here they are only decoded.

The mode picks one of three pattern layouts:
- eight independent banks;
- four 2KB pairs;
- a mixed layout.

It also picks the nametable arrangement, and whether nametables come from ROM or from console RAM. An optional output register (OUT_REG) adds one cycle of latency so the translation can sit directly in front of a memory.

Top module: `ppu_bank_xlat`

## Requirements
- R1: With OUT_REG=1, while rst_n is low all four outputs are 0.
- R2: xl_valid is 1 only for addresses below 0x3000. For any address at or above 0x3000, xl_valid, xl_rom, xl_rom_page and xl_ram_page are all 0.
- R3: When bank_mode[1:0]=0, the pattern slot s=addr[12:10] maps to register s.
- R4: When bank_mode[1:0]=1, pattern slots form pairs. Slot s maps to register s/2.
- R5: When bank_mode[1:0] is 2 or 3:
  - slots 0 to 3 map to registers 0 to 3 directly;
  - slots 4 and 5 map to register 4;
  - slots 6 and 7 map to register 5.
- R6: For a paired slot with bank_mode[5]=1, the page is the register with bit 0 replaced by slot bit 0. With bank_mode[5]=0, the page is the register unchanged.
- R7: Pattern accesses always give xl_rom=1. Nametable accesses give xl_rom=bank_mode[4]. xl_rom_page is 0 whenever xl_rom=0. xl_ram_page is 0 except for a nametable access in RAM mode.
- R8: The quadrant is q=addr[11:10]. Let m=bank_mode&0x2F, and let a and b be registers 6 and 7 with bit 0 cleared. The fixed arrangements are:
  - m in {0x20,0x27}: the quadrants give a, a|1, b, b|1;
  - m in {0x23,0x24}: a, b, a|1, b|1;
  - m in {0x28,0x2F}: a, a, b, b;
  - m in {0x2B,0x2C}: a|1, b|1, a|1, b|1.
- R9: For any other m, the quadrant value is chosen by bank_mode[2:0]:
  - 0, 6 or 7: registers 6, 6, 7, 7;
  - 1 or 5: registers 4, 5, 6, 7;
  - 2, 3 or 4: registers 6, 7, 6, 7.
- R10: In RAM mode (bank_mode[4]=0), xl_ram_page is bit 0 of the quadrant value from R8/R9. So the fixed arrangements give, per quadrant:
  - vertical: 0,1,0,1;
  - horizontal: 0,0,1,1;
  - single page 0;
  - single page 1.
- R11: With OUT_REG=1, the outputs reflect the inputs sampled at the previous rising clock edge. Changing the inputs leaves the outputs unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| ppu_addr | input | ADDR_W | Picture-processor address |
| bank_mode | input | 8 | Banking-mode value |
| bank_regs | input | 8*BANK_W | Eight character bank registers, register i at [i*BANK_W +: BANK_W] |
| xl_valid | output | 1 | Address lies inside the translated window |
| xl_rom | output | 1 | Access is served from character ROM |
| xl_rom_page | output | BANK_W | Character-ROM 1KB page number |
| xl_ram_page | output | 1 | Console nametable RAM page select |

## Verification
On every cycle the bound checker enforces these properties:
- the window rule;
- the quiet outputs outside it;
- the ROM/RAM source choice;
- the direct pattern layout;
- the low bit of split pairs;
- the two single-page RAM arrangements.

All of these are judged against the inputs of the cycle before. Only the bench's sweep can show that each of the 256 mode values routes the correct register to each of the twelve regions. That includes the exceptional masked values that override the general rule, the mixed pattern layout, and the one-cycle output timing.

// File: rtl/ppu_bank_pkg.sv
`timescale 1ns/1ps
package ppu_bank_pkg;
   localparam int NUM_BANK_REGS = 8;
   localparam int NUM_PAT_SLOTS = 8;
   localparam int NUM_NT_QUADS  = 4;
   localparam int MODE_W        = 8;
   localparam int MB_NT_ROM     = 4;   // mode bit: nametables from ROM
   localparam int MB_PAIR_SPLIT = 5;   // mode bit: split paired banks
   localparam logic [MODE_W-1:0] NT_FIXED_MASK = 8'h2F;

   typedef enum logic [1:0] {
      PL_EIGHT = 2'd0,
      PL_PAIRS = 2'd1,
      PL_MIXED = 2'd2
   } pat_layout_e;

   typedef enum logic [2:0] {
      NA_VERT   = 3'd0,
      NA_HORZ   = 3'd1,
      NA_ONE_LO = 3'd2,
      NA_ONE_HI = 3'd3,
      NA_R6677  = 3'd4,
      NA_R4567  = 3'd5,
      NA_R6767  = 3'd6
   } nt_arr_e;

   typedef struct packed {
      logic valid;
      logic rom;
      logic ram_pg;
   } xl_flags_t;

   function automatic pat_layout_e pat_layout(input logic [MODE_W-1:0] mode);
      case (mode[1:0])
         2'd0:    return PL_EIGHT;
         2'd1:    return PL_PAIRS;
         default: return PL_MIXED;
      endcase
   endfunction

   function automatic nt_arr_e nt_arr(input logic [MODE_W-1:0] mode);
      case (mode & NT_FIXED_MASK)
         8'h20, 8'h27: return NA_VERT;
         8'h23, 8'h24: return NA_HORZ;
         8'h28, 8'h2F: return NA_ONE_LO;
         8'h2B, 8'h2C: return NA_ONE_HI;
         default: begin
            case (mode[2:0])
               3'd1, 3'd5:       return NA_R4567;
               3'd2, 3'd3, 3'd4: return NA_R6767;
               default:          return NA_R6677;
            endcase
         end
      endcase
   endfunction
endpackage

// File: rtl/ppu_pat_slot_map.sv
`timescale 1ns/1ps
module ppu_pat_slot_map
   import ppu_bank_pkg::*;
#(
   parameter int BANK_W = 8
) (
   input  logic [MODE_W-1:0]               mode,
   input  logic [NUM_BANK_REGS*BANK_W-1:0] regs,
   input  logic [2:0]                      slot,
   output logic [BANK_W-1:0]               page
);
   localparam int MIX_DIRECT = NUM_PAT_SLOTS / 2;

   function automatic logic [BANK_W-1:0] pair_pick(
      input logic [BANK_W-1:0] v, input logic odd, input logic split);
      return split ? {v[BANK_W-1:1], odd} : v;
   endfunction

   pat_layout_e layout;
   logic        split;
   logic [BANK_W-1:0] slot_page [NUM_PAT_SLOTS];

   assign layout = pat_layout(mode);
   assign split  = mode[MB_PAIR_SPLIT];

   for (genvar s = 0; s < NUM_PAT_SLOTS; s++) begin : g_slot
      localparam int   DIR_IDX  = s;
      localparam int   PAIR_IDX = s / 2;
      localparam int   MIX_IDX  = (s < MIX_DIRECT) ? s : MIX_DIRECT + (s - MIX_DIRECT) / 2;
      localparam logic MIX_PAIR = (s >= MIX_DIRECT);
      localparam logic ODD      = 1'(s % 2);

      logic [BANK_W-1:0] r_dir, r_pair, r_mix;
      assign r_dir  = regs[DIR_IDX*BANK_W  +: BANK_W];
      assign r_pair = regs[PAIR_IDX*BANK_W +: BANK_W];
      assign r_mix  = regs[MIX_IDX*BANK_W  +: BANK_W];

      always_comb begin
         case (layout)
            PL_EIGHT: slot_page[s] = r_dir;
            PL_PAIRS: slot_page[s] = pair_pick(r_pair, ODD, split);
            default:  slot_page[s] = pair_pick(r_mix, ODD, split & MIX_PAIR);
         endcase
      end
   end

   assign page = slot_page[slot];
endmodule

// File: rtl/ppu_nt_quad_map.sv
`timescale 1ns/1ps
module ppu_nt_quad_map
   import ppu_bank_pkg::*;
#(
   parameter int BANK_W = 8
) (
   input  logic [MODE_W-1:0]               mode,
   input  logic [NUM_BANK_REGS*BANK_W-1:0] regs,
   input  logic [1:0]                      quad,
   output logic [BANK_W-1:0]               value
);
   localparam int IDX_A   = 6;
   localparam int IDX_B   = 7;
   localparam int IDX_LOW = 4;

   nt_arr_e arr;
   logic [BANK_W-1:0] reg_a, reg_b;
   logic [BANK_W-1:0] quad_val [NUM_NT_QUADS];

   assign arr   = nt_arr(mode);
   assign reg_a = regs[IDX_A*BANK_W +: BANK_W];
   assign reg_b = regs[IDX_B*BANK_W +: BANK_W];

   for (genvar q = 0; q < NUM_NT_QUADS; q++) begin : g_quad
      localparam logic Q_HI = 1'(q / 2);
      localparam logic Q_LO = 1'(q % 2);
      logic [BANK_W-1:0] by_hi, by_lo, r_seq;

      assign by_hi = Q_HI ? reg_b : reg_a;
      assign by_lo = Q_LO ? reg_b : reg_a;
      assign r_seq = regs[(IDX_LOW + q)*BANK_W +: BANK_W];

      always_comb begin
         case (arr)
            NA_VERT:   quad_val[q] = {by_hi[BANK_W-1:1], Q_LO};
            NA_HORZ:   quad_val[q] = {by_lo[BANK_W-1:1], Q_HI};
            NA_ONE_LO: quad_val[q] = {by_hi[BANK_W-1:1], 1'b0};
            NA_ONE_HI: quad_val[q] = {by_lo[BANK_W-1:1], 1'b1};
            NA_R4567:  quad_val[q] = r_seq;
            NA_R6767:  quad_val[q] = by_lo;
            default:   quad_val[q] = by_hi;
         endcase
      end
   end

   assign value = quad_val[quad];
endmodule

// File: rtl/ppu_xlat_out_stage.sv
`timescale 1ns/1ps
module ppu_xlat_out_stage
   import ppu_bank_pkg::*;
#(
   parameter int BANK_W  = 8,
   parameter int OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  xl_flags_t         flags_d,
   input  logic [BANK_W-1:0] page_d,
   output xl_flags_t         flags_q,
   output logic [BANK_W-1:0] page_q
);
   if (OUT_REG != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags_q <= '0;
            page_q  <= '0;
         end else begin
            flags_q <= flags_d;
            page_q  <= page_d;
         end
      end
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign flags_q = flags_d;
      assign page_q  = page_d;
   end
endmodule

// File: rtl/ppu_bank_xlat.sv
`timescale 1ns/1ps
module ppu_bank_xlat
   import ppu_bank_pkg::*;
#(
   parameter int ADDR_W  = 14,
   parameter int BANK_W  = 8,
   parameter int OUT_REG = 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ADDR_W-1:0]               ppu_addr,
   input  logic [MODE_W-1:0]               bank_mode,
   input  logic [NUM_BANK_REGS*BANK_W-1:0] bank_regs,
   output logic                            xl_valid,
   output logic                            xl_rom,
   output logic [BANK_W-1:0]               xl_rom_page,
   output logic                            xl_ram_page
);
   localparam logic [ADDR_W-1:0] PAT_LIMIT = ADDR_W'(32'h2000);
   localparam logic [ADDR_W-1:0] NT_LIMIT  = ADDR_W'(32'h3000);

   initial begin
      assert (ADDR_W >= 14) else $error("ppu_bank_xlat: ADDR_W must be at least 14");
      assert (BANK_W >= 2)  else $error("ppu_bank_xlat: BANK_W must be at least 2");
      assert (OUT_REG == 0 || OUT_REG == 1) else $error("ppu_bank_xlat: OUT_REG must be 0 or 1");
   end

   logic in_range, in_pat, in_nt, nt_rom;
   logic [2:0] slot;
   logic [1:0] quad;
   logic [BANK_W-1:0] pat_page, nt_val, page_d;
   xl_flags_t flags_d, flags_q;
   logic unused_addr_low;

   assign unused_addr_low = ^ppu_addr[9:0];
   assign in_range = (ppu_addr < NT_LIMIT);
   assign in_pat   = (ppu_addr < PAT_LIMIT);
   assign in_nt    = in_range & ~in_pat;
   assign slot     = ppu_addr[12:10];
   assign quad     = ppu_addr[11:10];
   assign nt_rom   = bank_mode[MB_NT_ROM];

   ppu_pat_slot_map #(.BANK_W(BANK_W)) u_pat (
      .mode (bank_mode),
      .regs (bank_regs),
      .slot (slot),
      .page (pat_page)
   );

   ppu_nt_quad_map #(.BANK_W(BANK_W)) u_nt (
      .mode  (bank_mode),
      .regs  (bank_regs),
      .quad  (quad),
      .value (nt_val)
   );

   always_comb begin
      flags_d.valid  = in_range;
      flags_d.rom    = in_pat | (in_nt & nt_rom);
      flags_d.ram_pg = in_nt & ~nt_rom & nt_val[0];
      if (in_pat)               page_d = pat_page;
      else if (in_nt && nt_rom) page_d = nt_val;
      else                      page_d = '0;
   end

   ppu_xlat_out_stage #(.BANK_W(BANK_W), .OUT_REG(OUT_REG)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_d (flags_d),
      .page_d  (page_d),
      .flags_q (flags_q),
      .page_q  (xl_rom_page)
   );

   assign xl_valid    = flags_q.valid;
   assign xl_rom      = flags_q.rom;
   assign xl_ram_page = flags_q.ram_pg;
endmodule

// File: rtl/ppu_bank_xlat_chk.sv
`timescale 1ns/1ps
module ppu_bank_xlat_chk #(
   parameter int ADDR_W  = 14,
   parameter int BANK_W  = 8,
   parameter int OUT_REG = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   ppu_addr,
   input logic [7:0]          bank_mode,
   input logic [8*BANK_W-1:0] bank_regs,
   input logic                xl_valid,
   input logic                xl_rom,
   input logic [BANK_W-1:0]   xl_rom_page,
   input logic                xl_ram_page
);
   localparam logic [ADDR_W-1:0] PAT_LIMIT = ADDR_W'(32'h2000);
   localparam logic [ADDR_W-1:0] NT_LIMIT  = ADDR_W'(32'h3000);

   logic [ADDR_W-1:0]   s_addr;
   logic [7:0]          s_mode;
   logic [8*BANK_W-1:0] s_regs;
   logic                s_ok;

   if (OUT_REG != 0) begin : g_seen_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_ok <= 1'b0; s_addr <= '0; s_mode <= '0; s_regs <= '0;
         end else begin
            s_ok <= 1'b1; s_addr <= ppu_addr; s_mode <= bank_mode; s_regs <= bank_regs;
         end
      end
   end else begin : g_seen_comb
      always_comb begin
         s_ok = rst_n; s_addr = ppu_addr; s_mode = bank_mode; s_regs = bank_regs;
      end
   end

   logic s_rng, s_pat, s_nt;
   logic [2:0] s_slot;
   logic [7:0] s_fix;
   assign s_rng  = s_addr < NT_LIMIT;
   assign s_pat  = s_addr < PAT_LIMIT;
   assign s_nt   = s_rng && !s_pat;
   assign s_slot = s_addr[12:10];
   assign s_fix  = s_mode & 8'h2F;

   assert_window_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      s_ok |-> (xl_valid == s_rng));
   assert_outside_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ok && !s_rng) |-> (!xl_rom && xl_rom_page == '0 && !xl_ram_page));
   assert_pattern_rom_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ok && s_pat) |-> (xl_rom && !xl_ram_page));
   assert_nt_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ok && s_nt) |-> (xl_rom == s_mode[4]));
   assert_ram_no_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ok && s_nt && !s_mode[4]) |-> (xl_rom_page == '0));
   assert_direct_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ok && s_pat && s_mode[1:0] == 2'd0) |-> (xl_rom_page == s_regs[s_slot*BANK_W +: BANK_W]));
   assert_split_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ok && s_pat && s_mode[5] && s_mode[1:0] == 2'd1) |-> (xl_rom_page[0] == s_slot[0]));
   assert_single_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ok && s_nt && !s_mode[4] && (s_fix == 8'h28 || s_fix == 8'h2F)) |-> !xl_ram_page);
   assert_single_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ok && s_nt && !s_mode[4] && (s_fix == 8'h2B || s_fix == 8'h2C)) |-> xl_ram_page);
endmodule

bind ppu_bank_xlat ppu_bank_xlat_chk #(
   .ADDR_W(ADDR_W), .BANK_W(BANK_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ppu_addr(ppu_addr), .bank_mode(bank_mode),
   .bank_regs(bank_regs), .xl_valid(xl_valid), .xl_rom(xl_rom),
   .xl_rom_page(xl_rom_page), .xl_ram_page(xl_ram_page)
);

// File: tb/ppu_bank_xlat_bench.sv
`timescale 1ns/1ps
module ppu_bank_xlat_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] addr = '0;
   logic [7:0]  mode = '0;
   logic [7:0]  rg [8];
   logic [63:0] regs_flat;
   logic        o_valid, o_rom, o_ram;
   logic [7:0]  o_page;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic [10:0] prev_exp = '0;

   always #10 clk = ~clk;

   for (genvar i = 0; i < 8; i++) begin : g_flat
      assign regs_flat[i*8 +: 8] = rg[i];
   end

   ppu_bank_xlat u_ppu_bank_xlat (
      .clk(clk), .rst_n(rst_n), .ppu_addr(addr), .bank_mode(mode),
      .bank_regs(regs_flat), .xl_valid(o_valid), .xl_rom(o_rom),
      .xl_rom_page(o_page), .xl_ram_page(o_ram)
   );

   // expected result packed as {valid, rom, page[7:0], ram}
   function automatic logic [10:0] model(input logic [13:0] a, input logic [7:0] m,
                                         output string tag);
      logic [7:0] r6e, r7e, v;
      int s, q, idx;
      bit paired;
      r6e = {rg[6][7:1], 1'b0};
      r7e = {rg[7][7:1], 1'b0};
      if (a >= 14'h3000) begin
         tag = "R2";
         return 11'd0;
      end
      if (a < 14'h2000) begin
         s = int'(a[12:10]);
         if (m[1:0] == 2'd0)      begin idx = s;     paired = 0; tag = "R3"; end
         else if (m[1:0] == 2'd1) begin idx = s / 2; paired = 1; tag = "R4"; end
         else if (s < 4)          begin idx = s;     paired = 0; tag = "R5"; end
         else begin idx = (s == 4 || s == 5) ? 4 : 5; paired = 1; tag = "R5"; end
         v = rg[idx];
         if (paired && m[5]) begin
            v[0] = (s % 2 == 1);
            tag = "R6";
         end
         return {1'b1, 1'b1, v, 1'b0};
      end
      q = int'(a[11:10]);
      case (m & 8'h2F)
         8'h20, 8'h27: begin tag = "R8"; v = (q == 0) ? r6e : (q == 1) ? (r6e | 8'd1) : (q == 2) ? r7e : (r7e | 8'd1); end
         8'h23, 8'h24: begin tag = "R8"; v = (q == 0) ? r6e : (q == 1) ? r7e : (q == 2) ? (r6e | 8'd1) : (r7e | 8'd1); end
         8'h28, 8'h2F: begin tag = "R8"; v = (q < 2) ? r6e : r7e; end
         8'h2B, 8'h2C: begin tag = "R8"; v = (q % 2 == 0) ? (r6e | 8'd1) : (r7e | 8'd1); end
         default: begin
            tag = "R9";
            case (m[2:0])
               3'd1, 3'd5:       v = rg[4 + q];
               3'd2, 3'd3, 3'd4: v = (q % 2 == 0) ? rg[6] : rg[7];
               default:          v = (q < 2) ? rg[6] : rg[7];
            endcase
         end
      endcase
      if (m[4]) return {1'b1, 1'b1, v, 1'b0};
      tag = (tag == "R8") ? "R10" : "R7";
      return {1'b1, 1'b0, 8'd0, v[0]};
   endfunction

   task automatic compare(input logic [10:0] exp, input string tag);
      logic [10:0] act;
      act = {o_valid, o_rom, o_page, o_ram};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s addr=%h mode=%h actual=%h expected=%h", tag, addr, mode, act, exp);
      end
   endtask

   // called at a falling edge: drive, confirm outputs hold, then check next falling edge
   task automatic apply(input logic [13:0] a, input logic [7:0] m);
      logic [10:0] e;
      string tag;
      addr = a;
      mode = m;
      e = model(a, m, tag);
      #2;
      compare(prev_exp, "R11");
      @(negedge clk);
      compare(e, tag);
      prev_exp = e;
   endtask

   task automatic random_regs();
      for (int i = 0; i < 8; i++) rg[i] = 8'($urandom);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      random_regs();
      addr = 14'h0400;
      mode = 8'h3F;
      repeat (3) @(negedge clk);
      compare(11'd0, "R1");
      rst_n = 1'b1;
      // directed corners
      rg[6] = 8'h5A; rg[7] = 8'hC3; rg[4] = 8'h11; rg[5] = 8'h22;
      apply(14'h3000, 8'h10);
      apply(14'h3FFF, 8'h00);
      apply(14'h1FFF, 8'h22);
      apply(14'h2000, 8'h30);
      apply(14'h2FFF, 8'h27);
      apply(14'h2400, 8'h27);
      apply(14'h2800, 8'h24);
      apply(14'h2C00, 8'h2B);
      apply(14'h2000, 8'h2F);
      apply(14'h1400, 8'h21);
      apply(14'h1C00, 8'h03);
      // full mode sweep over all twelve 1KB regions
      for (int m = 0; m < 256; m++) begin
         random_regs();
         for (int r = 0; r < 12; r++)
            apply(14'((r << 10) | ($urandom % 1024)), 8'(m));
      end
      // random addresses across the whole space
      for (int k = 0; k < 400; k++) begin
         if (k % 16 == 0) random_regs();
         apply(14'($urandom), 8'($urandom));
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule